// File: doc/BRIEF.md
# Reset and Interrupt Recognition Unit

This unit sits beside the timing generator and the instruction register of a small 8-bit processor core. Once per machine cycle it samples the active-low reset, non-maskable and maskable interrupt pins. It then decides when the core abandons normal fetch and begins a break response. The timing generator supplies the state of the current cycle as single-bit flags. The decoder supplies a flag that marks the running opcode as a branch.

Three results come back. The first is a request that forces the timing generator into the T0 state on the next cycle. The second holds the bus in read-only mode while a reset is being serviced. The third arms a break injection, so that the next fetch loads the all-zero break opcode into the instruction register in place of the fetched byte. The unit also holds that register. It keeps a complemented predecode copy of the fetched byte and presents the true opcode from the T2 cycle until the next fetch. Pending interrupt state is dropped in the cycle that follows the second vector cycle of the break. That drop is held off while reset is still being sensed.

Top module: `irq_reset_recog`

## Requirements
- R1: `forceT0` is 1 during the cycle that follows a rising clock edge at which `resN` was 0 (the sense cycle), and 0 during the cycle that follows an edge at which `resN` was 1.
- R2: `readOnly` becomes 1 in the cycle after a sense cycle and stays 1 until it is released as described in R9.
- R3: A 1-to-0 transition of `nmiN` is detected when the pin is sampled once per cycle, and is held as pending. A pin held at 0 after the pending state has been cleared does not raise a new request. The pending NMI is discarded in any sense cycle.
- R4: `irqN` is level-sensitive. It is sampled every cycle and ignored while `irqDisable` is 1.
- R5: A request from a pending reset, a pending NMI or a sampled IRQ sets `injectBreak` at the end of a cycle with `inT0`=1. A cycle with `inT2`=1 and `isBranch`=0 does not set it.
- R6: For branch opcodes (`isBranch`=1), a cycle with `inT2`=1 is also a recognition window.
- R7: At the end of a cycle with `fetchCycle`=1 and `injectBreak`=1, `irValue` becomes 8'h00 and `injectBreak` returns to 0.
- R8: At the end of a cycle with `fetchCycle`=1 and `injectBreak`=0, `irValue` becomes the fetched `fetchByte` and holds until the next fetch.
- R9: At the end of the cycle after a cycle with `vec1Cycle`=1, the pending reset and pending NMI are cleared, unless that cycle is a sense cycle. In that case both stay set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| resN | input | 1 | Reset pin, active low |
| nmiN | input | 1 | Non-maskable interrupt pin, active low, edge-detected |
| irqN | input | 1 | Maskable interrupt pin, active low, level |
| irqDisable | input | 1 | Interrupt-disable flag; masks `irqN` when 1 |
| inT0 | input | 1 | Current cycle is a T0 state |
| inT2 | input | 1 | Current cycle is a T2 state |
| isBranch | input | 1 | Opcode in the instruction register is a conditional branch |
| fetchCycle | input | 1 | Current cycle reads an opcode (T1) |
| vec1Cycle | input | 1 | Current cycle is the second vector cycle of a break |
| fetchByte | input | 8 | Byte read from the bus during the fetch cycle |
| forceT0 | output | 1 | Forces T0 on the following cycle |
| readOnly | output | 1 | Holds the bus in read mode |
| injectBreak | output | 1 | Break start armed; next fetch loads the zero opcode |
| irValue | output | 8 | Instruction register contents |

## Verification
Every output changes at the first rising edge after its cause. `forceT0` follows a low reset pin by one edge. `readOnly` trails `forceT0` by one more edge. An NMI edge needs two edges to become pending and a third, in a window cycle, to arm `injectBreak`. The release of R9 lands two edges after the `vec1Cycle` cycle. The bench drives inputs on the falling edge and advances one full cycle. It compares all four outputs with a cycle model on the next falling edge. The directed sequences add checks at the exact cycle where each of these edge counts predicts a change.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;
  parameter int DATA_W = 8;

  // strobes from recognition control to the instruction-register path
  typedef struct packed {
    logic loadIr;     // fetch completes at this edge
    logic loadZero;   // substitute the break opcode
  } irStrobes_t;
endpackage

// File: rtl/irq_recog_ctrl.sv
module irq_recog_ctrl
  import irq_recog_pkg::*;
(
  input  logic       clk,
  input  logic       resN,
  input  logic       nmiN,
  input  logic       irqN,
  input  logic       irqDisable,
  input  logic       inT0,
  input  logic       inT2,
  input  logic       isBranch,
  input  logic       fetchCycle,
  input  logic       vec1Cycle,
  output logic       forceT0,
  output logic       readOnly,
  output logic       injectBreak,
  output irStrobes_t strobes
);
  logic resSensed;
  logic resPending;
  logic nmiLevel;
  logic nmiLevelPrev;
  logic nmiPending;
  logic irqLevel;
  logic breakArmed;
  logic clearCycle;

  logic nmiEdge;
  logic window;
  logic request;
  logic clearOk;

  assign nmiEdge = nmiLevel && !nmiLevelPrev;
  assign window  = inT0 || (inT2 && isBranch);
  assign request = resSensed || resPending || nmiPending || irqLevel;
  assign clearOk = clearCycle && !resSensed;

  // pin sampling, once per machine cycle
  always_ff @(posedge clk) begin
    resSensed    <= !resN;
    nmiLevel     <= !nmiN;
    nmiLevelPrev <= nmiLevel;
    irqLevel     <= !irqN && !irqDisable;
    clearCycle   <= vec1Cycle;
  end

  // reset pending: set when sensed, released by the post-vector strobe
  always_ff @(posedge clk) begin
    if (resSensed)    resPending <= 1'b1;
    else if (clearOk) resPending <= 1'b0;
  end

  // nmi pending: edge latch, discarded by a sense cycle
  always_ff @(posedge clk) begin
    if (resSensed)    nmiPending <= 1'b0;
    else if (nmiEdge) nmiPending <= 1'b1;
    else if (clearOk) nmiPending <= 1'b0;
  end

  // break arming: only in a recognition window, dropped at the fetch
  always_ff @(posedge clk) begin
    if (window && request) breakArmed <= 1'b1;
    else if (fetchCycle)   breakArmed <= 1'b0;
  end

  assign forceT0          = resSensed;
  assign readOnly         = resPending;
  assign injectBreak      = breakArmed;
  assign strobes.loadIr   = fetchCycle;
  assign strobes.loadZero = breakArmed;

  // R2
  readonly_hold_chk: assert property (@(posedge clk) disable iff (!resN)
    (resPending && !clearCycle) |=> readOnly);

  // R9
  clear_block_chk: assert property (@(posedge clk) disable iff (!resN)
    (clearCycle && resSensed && resPending) |=> readOnly);

  // R5
  break_window_chk: assert property (@(posedge clk) disable iff (!resN)
    $rose(injectBreak) |-> $past(inT0 || (inT2 && isBranch)));

  // R7
  break_hold_chk: assert property (@(posedge clk) disable iff (!resN)
    (injectBreak && !fetchCycle) |=> injectBreak);
endmodule

// File: rtl/ir_load_path.sv
module ir_load_path
  import irq_recog_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         holdOff,
  input  irStrobes_t   strobes,
  input  logic [W-1:0] fetchByte,
  output logic [W-1:0] irValue
);
  localparam logic [W-1:0] BREAK_OP = '0;

  logic [W-1:0] predecode;  // complement of the fetched byte
  logic         zeroSel;

  always_ff @(posedge clk) begin
    if (strobes.loadIr) begin
      predecode <= ~fetchByte;
      zeroSel   <= strobes.loadZero;
    end
  end

  assign irValue = zeroSel ? BREAK_OP : ~predecode;

  // R7
  zero_load_chk: assert property (@(posedge clk) disable iff (holdOff)
    (strobes.loadIr && strobes.loadZero) |=> (irValue == BREAK_OP));

  // R8
  ir_stable_chk: assert property (@(posedge clk) disable iff (holdOff)
    !strobes.loadIr |=> $stable(irValue));
endmodule

// File: rtl/irq_reset_recog.sv
module irq_reset_recog
  import irq_recog_pkg::*;
(
  input  logic              clk,
  input  logic              resN,
  input  logic              nmiN,
  input  logic              irqN,
  input  logic              irqDisable,
  input  logic              inT0,
  input  logic              inT2,
  input  logic              isBranch,
  input  logic              fetchCycle,
  input  logic              vec1Cycle,
  input  logic [DATA_W-1:0] fetchByte,
  output logic              forceT0,
  output logic              readOnly,
  output logic              injectBreak,
  output logic [DATA_W-1:0] irValue
);
  irStrobes_t strobes;

  irq_recog_ctrl ctrl_i (
    .clk(clk), .resN(resN), .nmiN(nmiN), .irqN(irqN), .irqDisable(irqDisable),
    .inT0(inT0), .inT2(inT2), .isBranch(isBranch), .fetchCycle(fetchCycle),
    .vec1Cycle(vec1Cycle), .forceT0(forceT0), .readOnly(readOnly),
    .injectBreak(injectBreak), .strobes(strobes)
  );

  ir_load_path #(.W(DATA_W)) path_i (
    .clk(clk), .holdOff(!resN), .strobes(strobes),
    .fetchByte(fetchByte), .irValue(irValue)
  );
endmodule

// File: tb/irq_reset_recog_tb_top.sv
module irq_reset_recog_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic resN = 1'b0, nmiN = 1'b1, irqN = 1'b1, irqDisable = 1'b0;
  logic inT0 = 1'b0, inT2 = 1'b0, isBranch = 1'b0, fetchCycle = 1'b1, vec1Cycle = 1'b0;
  logic [7:0] fetchByte = 8'h00;
  logic forceT0, readOnly, injectBreak;
  logic [7:0] irValue;

  irq_reset_recog dut_i (.*);

  int checks = 0, errors = 0;
  bit compareOn = 0;

  // cycle model state
  bit mResS, mResP, mNmiS, mNmiS1, mNmiP, mIrqS, mBrk, mClr, mZero, mIrKnown;
  logic [7:0] mByte;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit modelWindow(bit t0, bit t2, bit br);
    return t0 || (t2 && br);
  endfunction

  task automatic modelStep();
    bit nResS, nResP, nNmiP, nBrk, want;
    nResS = !resN;
    nResP = mResS ? 1'b1 : ((mClr && !mResS) ? 1'b0 : mResP);
    if (mResS) nNmiP = 0;
    else if (mNmiS && !mNmiS1) nNmiP = 1;
    else if (mClr) nNmiP = 0;
    else nNmiP = mNmiP;
    want = mResS || mResP || mNmiP || mIrqS;
    if (modelWindow(inT0, inT2, isBranch) && want) nBrk = 1;
    else if (fetchCycle) nBrk = 0;
    else nBrk = mBrk;
    if (fetchCycle) begin
      mZero = mBrk; mByte = fetchByte; mIrKnown = 1;
    end
    mNmiS1 = mNmiS; mNmiS = !nmiN;
    mIrqS = !irqN && !irqDisable;
    mClr = vec1Cycle;
    mResS = nResS; mResP = nResP; mNmiP = nNmiP; mBrk = nBrk;
  endtask

  // one machine cycle: inputs already driven, advance and compare
  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    if (compareOn) begin
      chk(forceT0 == mResS, "R1", forceT0, mResS);
      chk(readOnly == mResP, "R2", readOnly, mResP);
      chk(injectBreak == mBrk, "R5", injectBreak, mBrk);
      if (mIrKnown)
        chk(irValue == (mZero ? 8'h00 : mByte), "R8", irValue, mZero ? 8'h00 : mByte);
    end
  endtask

  task automatic idle();
    inT0 = 0; inT2 = 0; isBranch = 0; fetchCycle = 0; vec1Cycle = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    compareOn = 1;
    idle();
    tick();
    // R1 R2: reset held low
    chk(forceT0 == 1, "R1", forceT0, 1);
    chk(readOnly == 1, "R2", readOnly, 1);
    resN = 1; tick();
    chk(forceT0 == 0, "R1", forceT0, 0);
    chk(readOnly == 1, "R2", readOnly, 1);
    // R5: forced T0 recognizes the pending reset
    inT0 = 1; tick(); idle();
    chk(injectBreak == 1, "R5", injectBreak, 1);
    // R7: fetch loads the zero opcode
    fetchCycle = 1; fetchByte = 8'hA9; tick(); idle();
    chk(irValue == 8'h00, "R7", irValue, 0);
    chk(injectBreak == 0, "R7", injectBreak, 0);
    // R9: release two edges after vec1
    vec1Cycle = 1; tick(); idle();
    chk(readOnly == 1, "R9", readOnly, 1);
    tick();
    chk(readOnly == 0, "R9", readOnly, 0);
    // R8: plain fetch
    fetchCycle = 1; fetchByte = 8'h5A; tick(); idle();
    chk(irValue == 8'h5A, "R8", irValue, 8'h5A);
    // R4: masked IRQ is ignored in T0
    irqN = 0; irqDisable = 1; tick();
    inT0 = 1; tick(); idle();
    chk(injectBreak == 0, "R4", injectBreak, 0);
    irqDisable = 0; tick();
    // R5: non-branch T2 is not a window
    inT2 = 1; tick(); idle();
    chk(injectBreak == 0, "R5", injectBreak, 0);
    // R6: branch T2 is a window
    inT2 = 1; isBranch = 1; tick(); idle();
    chk(injectBreak == 1, "R6", injectBreak, 1);
    fetchCycle = 1; fetchByte = 8'h10; irqN = 1; tick(); idle();
    chk(irValue == 8'h00, "R7", irValue, 0);
    tick();
    // R3: NMI edge, then no retrigger while held low
    nmiN = 0; tick(); tick();
    inT0 = 1; tick(); idle();
    chk(injectBreak == 1, "R3", injectBreak, 1);
    fetchCycle = 1; tick(); idle();
    vec1Cycle = 1; tick(); idle(); tick();
    inT0 = 1; tick(); idle();
    chk(injectBreak == 0, "R3", injectBreak, 0);
    nmiN = 1; tick();
    // R9: clear blocked while reset still sensed
    resN = 0; tick();
    chk(forceT0 == 1, "R1", forceT0, 1);
    resN = 1; tick();
    vec1Cycle = 1; resN = 0; tick(); idle();
    resN = 1; tick();
    chk(readOnly == 1, "R9", readOnly, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      resN       = ($urandom % 16) != 0;
      nmiN       = ($urandom % 8) != 0;
      irqN       = ($urandom % 4) != 0;
      irqDisable = ($urandom % 3) == 0;
      inT0       = ($urandom % 4) == 0;
      inT2       = ($urandom % 4) == 0;
      isBranch   = ($urandom % 2) == 0;
      fetchCycle = ($urandom % 4) == 0;
      vec1Cycle  = ($urandom % 8) == 0;
      fetchByte  = 8'($urandom);
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule